// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer

This block sits between a processor whose bus shares pins between address, data and status, and a memory that needs a steady 20-bit address, separate read and write strobes and a one-way data path. A bus cycle lasts four clock states. In the first state the processor raises an address strobe while the low address byte is on the shared byte pins and the top address nibble is on the four status-shared pins. Later in the cycle those pins carry data and status instead.

The block follows the shared pins while the address strobe is high, and keeps the captured value while the strobe is low. It behaves like a transparent latch, but it is built from clocked registers and a bypass multiplexer. The middle address byte is never shared, so it passes straight through. Two memory strobes, both active low, are formed from the processor's read and write requests and its memory-or-I/O select. A request for both at once selects neither. The data byte is steered toward memory or toward the processor by a direction input and an active-low enable. The two output-enable flags are never high together.

Top module: `bus_demux`

## Requirements
- R1: While `addr_strobe` is 1, `addr[7:0]` equals `bus_lo` and `addr[19:16]` equals `bus_hi` in the same cycle.
- R2: While `addr_strobe` is 0, `addr[7:0]` and `addr[19:16]` hold the values that `bus_lo` and `bus_hi` had at the last rising clock edge with `addr_strobe` at 1. Any change on those pins has no effect.
- R3: `addr[15:8]` always equals `bus_mid`, combinationally.
- R4: `mem_rd_n` is 0 exactly when `rd_req_n` is 0, `wr_req_n` is 1 and `io_sel` is 0. An `io_sel` of 0 selects memory and 1 selects I/O.
- R5: `mem_wr_n` is 0 exactly when `wr_req_n` is 0, `rd_req_n` is 1 and `io_sel` is 0.
- R6: `mem_rd_n` and `mem_wr_n` are never 0 together. With both requests at 0, both strobes are 1.
- R7: With `xfer_en_n`=0 and `xmit`=1, the data moves toward memory: `mem_d_out` equals `bus_lo`, `mem_d_oe` is 1 and `cpu_d_oe` is 0.
- R8: With `xfer_en_n`=0 and `xmit`=0, the data moves toward the processor: `cpu_d_out` equals `mem_d_in`, `cpu_d_oe` is 1 and `mem_d_oe` is 0.
- R9: With `xfer_en_n`=1, `mem_d_oe` and `cpu_d_oe` are 0, and `mem_d_out` and `cpu_d_out` are 0.
- R10: During reset the held fields are cleared. With `addr_strobe` at 0, `addr[7:0]` and `addr[19:16]` read 0 whatever the pins carry.
- R11: A memory read of address 70C12H holds 7H on `addr[19:16]`, 0CH on `addr[15:8]` and 12H on `addr[7:0]` through the fourth state, and read data 30H appears on `cpu_d_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, clears the held fields |
| addr_strobe | input | 1 | High while the address is on the shared pins |
| bus_lo | input | 8 | Shared pins: low address byte, then data |
| bus_mid | input | 8 | Middle address byte, never shared |
| bus_hi | input | 4 | Shared pins: top address nibble, then status |
| io_sel | input | 1 | 0 = memory access, 1 = I/O access |
| rd_req_n | input | 1 | Processor read request, active low |
| wr_req_n | input | 1 | Processor write request, active low |
| xmit | input | 1 | Data direction: 1 = toward memory, 0 = toward processor |
| xfer_en_n | input | 1 | Data path enable, active low |
| mem_d_in | input | 8 | Data driven by the memory |
| addr | output | 20 | Demultiplexed address |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_d_out | output | 8 | Data toward memory |
| mem_d_oe | output | 1 | Drive enable for `mem_d_out` |
| cpu_d_out | output | 8 | Data toward the processor |
| cpu_d_oe | output | 1 | Drive enable for `cpu_d_out` |

## Verification
A held field that is loaded on the wrong edge, or not loaded at all, shows on `addr` in the first cycle after the address strobe falls. That is the cycle in which the shared pins switch to data or status. A held field that loads while the strobe is low shows within one clock of a pin change. Every second through fourth state of every swept cycle is therefore compared against the address sent in the first state. The strobe and steering paths are combinational, so an error there appears in the same cycle as the input pattern that triggers it. All input combinations are swept.

// File: rtl/bus_demux_pkg.sv
package bus_demux_pkg;
    localparam int LO_W  = 8;
    localparam int MID_W = 8;
    localparam int HI_W  = 4;
    localparam int ADDR_W = LO_W + MID_W + HI_W;

    typedef enum logic [1:0] {
        PATH_OFF    = 2'd0,
        PATH_TO_MEM = 2'd1,
        PATH_TO_CPU = 2'd2
    } path_e;
endpackage

// File: rtl/field_hold.sv
module field_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate,
    input  logic [W-1:0] pins,
    output logic [W-1:0] held
);
    typedef struct packed {
        logic [W-1:0] val;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (gate) begin
            s_d.val = pins;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // transparent while gate is high, registered copy otherwise
    assign held = gate ? pins : s_q.val;
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen (
    input  logic io_sel,
    input  logic rd_req_n,
    input  logic wr_req_n,
    output logic mem_rd_n,
    output logic mem_wr_n
);
    logic want_rd, want_wr, conflict;

    always_comb begin
        want_rd  = !rd_req_n && !io_sel;
        want_wr  = !wr_req_n && !io_sel;
        conflict = !rd_req_n && !wr_req_n;
        mem_rd_n = !(want_rd && !conflict);
        mem_wr_n = !(want_wr && !conflict);
    end
endmodule

// File: rtl/data_steer.sv
module data_steer
    import bus_demux_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          xmit,
    input  logic          xfer_en_n,
    input  logic [DW-1:0] from_cpu,
    input  logic [DW-1:0] from_mem,
    output logic [DW-1:0] to_mem,
    output logic          to_mem_oe,
    output logic [DW-1:0] to_cpu,
    output logic          to_cpu_oe
);
    path_e path;

    always_comb begin
        if (xfer_en_n) begin
            path = PATH_OFF;
        end else if (xmit) begin
            path = PATH_TO_MEM;
        end else begin
            path = PATH_TO_CPU;
        end
    end

    always_comb begin
        to_mem    = '0;
        to_cpu    = '0;
        to_mem_oe = 1'b0;
        to_cpu_oe = 1'b0;
        unique case (path)
            PATH_TO_MEM: begin
                to_mem    = from_cpu;
                to_mem_oe = 1'b1;
            end
            PATH_TO_CPU: begin
                to_cpu    = from_mem;
                to_cpu_oe = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_demux.sv
module bus_demux
    import bus_demux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strobe,
    input  logic [LO_W-1:0]   bus_lo,
    input  logic [MID_W-1:0]  bus_mid,
    input  logic [HI_W-1:0]   bus_hi,
    input  logic              io_sel,
    input  logic              rd_req_n,
    input  logic              wr_req_n,
    input  logic              xmit,
    input  logic              xfer_en_n,
    input  logic [LO_W-1:0]   mem_d_in,
    output logic [ADDR_W-1:0] addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [LO_W-1:0]   mem_d_out,
    output logic              mem_d_oe,
    output logic [LO_W-1:0]   cpu_d_out,
    output logic              cpu_d_oe
);
    logic [LO_W-1:0] lo_held;
    logic [HI_W-1:0] hi_held;

    field_hold #(.W(LO_W)) u_lo (
        .clk  (clk),
        .rst_n(rst_n),
        .gate (addr_strobe),
        .pins (bus_lo),
        .held (lo_held)
    );

    field_hold #(.W(HI_W)) u_hi (
        .clk  (clk),
        .rst_n(rst_n),
        .gate (addr_strobe),
        .pins (bus_hi),
        .held (hi_held)
    );

    assign addr = {hi_held, bus_mid, lo_held};

    strobe_gen u_strb (
        .io_sel  (io_sel),
        .rd_req_n(rd_req_n),
        .wr_req_n(wr_req_n),
        .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n)
    );

    data_steer #(.DW(LO_W)) u_steer (
        .xmit     (xmit),
        .xfer_en_n(xfer_en_n),
        .from_cpu (bus_lo),
        .from_mem (mem_d_in),
        .to_mem   (mem_d_out),
        .to_mem_oe(mem_d_oe),
        .to_cpu   (cpu_d_out),
        .to_cpu_oe(cpu_d_oe)
    );
endmodule

// File: rtl/bus_demux_chk.sv
module bus_demux_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_strobe,
    input logic [7:0]  bus_lo,
    input logic [3:0]  bus_hi,
    input logic        io_sel,
    input logic        rd_req_n,
    input logic        wr_req_n,
    input logic [19:0] addr,
    input logic        mem_rd_n,
    input logic        mem_wr_n,
    input logic        mem_d_oe,
    input logic        cpu_d_oe
);
    a_r2_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_strobe && $past(!addr_strobe)) |-> $stable({addr[19:16], addr[7:0]}));

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_strobe) |-> ({addr[19:16], addr[7:0]} == $past({bus_hi, bus_lo})));

    a_r4_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req_n && wr_req_n && !io_sel) |-> !mem_rd_n);

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));

    a_r7_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_d_oe && cpu_d_oe));
endmodule

bind bus_demux bus_demux_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_strobe(addr_strobe),
    .bus_lo     (bus_lo),
    .bus_hi     (bus_hi),
    .io_sel     (io_sel),
    .rd_req_n   (rd_req_n),
    .wr_req_n   (wr_req_n),
    .addr       (addr),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .mem_d_oe   (mem_d_oe),
    .cpu_d_oe   (cpu_d_oe)
);

// File: tb/bus_demux_tb.sv
module bus_demux_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_strobe = 1'b0;
    logic [7:0]  bus_lo = 8'h00;
    logic [7:0]  bus_mid = 8'h00;
    logic [3:0]  bus_hi = 4'h0;
    logic        io_sel = 1'b0;
    logic        rd_req_n = 1'b1;
    logic        wr_req_n = 1'b1;
    logic        xmit = 1'b0;
    logic        xfer_en_n = 1'b1;
    logic [7:0]  mem_d_in = 8'h00;
    logic [19:0] addr;
    logic        mem_rd_n, mem_wr_n, mem_d_oe, cpu_d_oe;
    logic [7:0]  mem_d_out, cpu_d_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bus_demux u_dut (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe),
        .bus_lo(bus_lo), .bus_mid(bus_mid), .bus_hi(bus_hi),
        .io_sel(io_sel), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
        .xmit(xmit), .xfer_en_n(xfer_en_n), .mem_d_in(mem_d_in),
        .addr(addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_d_out(mem_d_out), .mem_d_oe(mem_d_oe),
        .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive after a falling edge, sample 2 ns later
    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus_cycle(input logic [19:0] a, input logic [7:0] dat);
        step();
        addr_strobe = 1'b1; bus_lo = a[7:0]; bus_mid = a[15:8]; bus_hi = a[19:16];
        #2;
        chk("R1 lo", addr[7:0], a[7:0]);
        chk("R1 hi", addr[19:16], a[19:16]);
        chk("R3 mid", addr[15:8], a[15:8]);
        for (int t = 2; t <= 4; t++) begin
            step();
            addr_strobe = 1'b0;
            bus_lo = dat ^ 8'(t);
            bus_hi = ~a[19:16] ^ 4'(t);
            #2;
            chk("R2 lo", addr[7:0], a[7:0]);
            chk("R2 hi", addr[19:16], a[19:16]);
            chk("R3 mid", addr[15:8], a[15:8]);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bus_lo = 8'hAA; bus_hi = 4'h5; bus_mid = 8'h3C;
        repeat (3) step();
        #2;
        chk("R10 lo", addr[7:0], 8'h00);
        chk("R10 hi", addr[19:16], 4'h0);
        chk("R3 mid reset", addr[15:8], 8'h3C);
        step();
        rst_n = 1'b1;
        #2;
        chk("R10 lo after", addr[7:0], 8'h00);

        // R1 R2 R3 sweep: every low byte, rotating top nibble and middle byte
        for (int i = 0; i < 256; i++) begin
            logic [19:0] a;
            a = {4'(i * 7 + 3), 8'(i * 13 + 5), 8'(i)};
            bus_cycle(a, 8'(i ^ 8'h5A));
        end

        // R4 R5 R6 exhaustive strobe combinations
        for (int v = 0; v < 8; v++) begin
            logic r, w, s;
            step();
            r = v[0]; w = v[1]; s = v[2];
            rd_req_n = r; wr_req_n = w; io_sel = s;
            #2;
            chk("R4 rd", mem_rd_n, !(!r && w && !s));
            chk("R5 wr", mem_wr_n, !(!w && r && !s));
            chk("R6 overlap", (!mem_rd_n && !mem_wr_n), 1'b0);
        end
        rd_req_n = 1'b1; wr_req_n = 1'b1; io_sel = 1'b0;

        // R7 R8 R9 steering over several data values
        for (int v = 0; v < 64; v++) begin
            logic [7:0] cd, md;
            step();
            cd = 8'(v * 37 + 1); md = 8'(v * 91 + 2);
            bus_lo = cd; mem_d_in = md;
            xmit = v[0]; xfer_en_n = v[1];
            #2;
            if (v[1]) begin
                chk("R9 oe", {mem_d_oe, cpu_d_oe}, 2'b00);
                chk("R9 data", {mem_d_out, cpu_d_out}, 16'h0000);
            end else if (v[0]) begin
                chk("R7 data", mem_d_out, cd);
                chk("R7 oe", {mem_d_oe, cpu_d_oe}, 2'b10);
            end else begin
                chk("R8 data", cpu_d_out, md);
                chk("R8 oe", {mem_d_oe, cpu_d_oe}, 2'b01);
            end
        end
        xfer_en_n = 1'b1;

        // R11 worked read cycle
        step();
        addr_strobe = 1'b1; bus_lo = 8'h12; bus_mid = 8'h0C; bus_hi = 4'h7;
        io_sel = 1'b0; xmit = 1'b0;
        #2;
        chk("R11 T1 addr", addr, 20'h70C12);
        step();
        addr_strobe = 1'b0; bus_lo = 8'hFF; bus_hi = 4'h9; rd_req_n = 1'b0;
        #2;
        chk("R11 T2 addr", addr, 20'h70C12);
        chk("R11 T2 rd", mem_rd_n, 1'b0);
        step();
        xfer_en_n = 1'b0; mem_d_in = 8'h30; bus_lo = 8'h30;
        #2;
        chk("R11 T3 addr", addr, 20'h70C12);
        chk("R11 T3 data", cpu_d_out, 8'h30);
        step();
        #2;
        chk("R11 T4 addr", addr, 20'h70C12);
        chk("R11 T4 data", cpu_d_out, 8'h30);
        step();
        rd_req_n = 1'b1; xfer_en_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule